// File: doc/BRIEF.md
# Asynchronous Memory Strobe Timing Sequencer

This block runs single read and write cycles on an 8-bit asynchronous external memory bus, such as the data port of a NAND flash device. Each access passes through four timed phases: setup, strobe, hold and a closing turnaround gap. During the first three phases the chip select is active. The output-enable strobe (for reads) or the write-enable strobe (for writes) is active only during the strobe phase.

The phase lengths come from one 32-bit timing word. Reads and writes each have their own setup, strobe and hold fields, and a shared field sets the turnaround length. Every field gives a duration of its value plus one clock. The timing word is sampled when a request is accepted, so software may rewrite it at any time without disturbing an access already in progress.

The request side has a valid/ready pair. A request carries a direction bit, address qualifier bits (for example command-latch and address-latch selects) and a write data byte. Read data is captured on the last clock of the read strobe. A one-clock completion pulse marks the end of the turnaround phase, and the block can accept a new request in that same cycle.

Top module: `amem_strobe_seq`

## Requirements
- R1: While reset is held and after it is released, with no request, chip select, output enable and write enable are all high (inactive), the data driver enable is low, the completion pulse is low and the request ready is high.
- R2: A write access holds setup for timing-word bits 29:26 plus one clocks, the write strobe for bits 25:20 plus one clocks, and hold for bits 19:17 plus one clocks, in that order.
- R3: A read access holds setup for timing-word bits 16:13 plus one clocks, the read strobe for bits 12:7 plus one clocks, and hold for bits 6:4 plus one clocks, in that order.
- R4: After hold, chip select is released for a turnaround of timing-word bits 3:2 plus one clocks. A one-clock completion pulse then marks the first cycle in which ready is high again.
- R5: Output enable goes low only in the strobe phase of a read, and write enable only in the strobe phase of a write. The two are never low together, and the data driver enable is never high while output enable is low.
- R6: Chip select stays low without a gap from the first setup clock through the last hold clock, and both strobes fall inside that window.
- R7: The read data output takes the value on the data input during the last strobe clock of a read. It keeps that value through later writes until the next read completes.
- R8: The address output, and for a write the data output with its driver enable high, stay at the values from the request from the first setup clock through the last hold clock.
- R9: Ready is low from acceptance until the completion pulse. A request presented while ready is low is ignored and does not alter the access in progress.
- R10: The timing word is sampled only at acceptance. Its bits 31:30 and 1:0 have no effect on timing, and changes made during an access do not change that access.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| cfg_word | input | 32 | Packed phase timing word |
| req_valid | input | 1 | Request present |
| req_write | input | 1 | 1 = write, 0 = read |
| req_addr | input | ADDR_W | Address qualifier bits for the access |
| req_wdata | input | DATA_W | Write data byte |
| req_ready | output | 1 | Block idle, request will be accepted |
| done | output | 1 | One-clock completion pulse |
| rdata | output | DATA_W | Last captured read data |
| mem_cs_n | output | 1 | Chip select, active low |
| mem_oe_n | output | 1 | Output enable (read strobe), active low |
| mem_we_n | output | 1 | Write enable (write strobe), active low |
| mem_addr | output | ADDR_W | Address qualifier bits to the device |
| mem_dout | output | DATA_W | Data driven toward the device |
| mem_dout_en | output | 1 | Data driver enable |
| mem_din | input | DATA_W | Data returned by the device |

## Verification
The bench drives an all-zero timing word to get single-clock phases, a word with every field at its maximum, and random words with the ignored bits set at random. It measures each phase length from the pins. An off-by-one counter would make a phase one clock short or long, and a swapped read/write field select would give lengths from the wrong field. The bench's device model changes the returned byte on every strobe clock, so a capture on any clock other than the last one yields a different value. The bench also rewrites the timing word and pulses a stray request in the middle of an access; a design that sampled either one late would change the phase lengths or the address on the bus.

// File: rtl/amem_pkg.sv
package amem_pkg;

    // Timing word layout (positions fixed by the register definition)
    localparam int CFG_W     = 32;
    localparam int SETUP_W   = 4;
    localparam int STROBE_W  = 6;
    localparam int HOLD_W    = 3;
    localparam int TURN_W    = 2;
    localparam int WSET_LSB  = 26;
    localparam int WSTB_LSB  = 20;
    localparam int WHLD_LSB  = 17;
    localparam int RSET_LSB  = 13;
    localparam int RSTB_LSB  = 7;
    localparam int RHLD_LSB  = 4;
    localparam int TURN_LSB  = 2;

    // Counter wide enough for the widest field
    localparam int CNT_W = (STROBE_W > SETUP_W) ? STROBE_W : SETUP_W;

    typedef enum logic [2:0] {
        PH_IDLE   = 3'd0,
        PH_SETUP  = 3'd1,
        PH_STROBE = 3'd2,
        PH_HOLD   = 3'd3,
        PH_TURN   = 3'd4
    } phase_e;

    typedef struct packed {
        logic [SETUP_W-1:0]  setup;
        logic [STROBE_W-1:0] strobe;
        logic [HOLD_W-1:0]   hold;
        logic [TURN_W-1:0]   turn;
    } timing_t;

endpackage

// File: rtl/amem_cfg_decode.sv
module amem_cfg_decode
    import amem_pkg::*;
(
    input  logic [CFG_W-1:0] cfg,
    input  logic             wr,
    output timing_t          tim
);

    timing_t rd_tim;
    timing_t wr_tim;

    always_comb begin
        rd_tim.setup  = cfg[RSET_LSB +: SETUP_W];
        rd_tim.strobe = cfg[RSTB_LSB +: STROBE_W];
        rd_tim.hold   = cfg[RHLD_LSB +: HOLD_W];
        rd_tim.turn   = cfg[TURN_LSB +: TURN_W];
        wr_tim.setup  = cfg[WSET_LSB +: SETUP_W];
        wr_tim.strobe = cfg[WSTB_LSB +: STROBE_W];
        wr_tim.hold   = cfg[WHLD_LSB +: HOLD_W];
        wr_tim.turn   = cfg[TURN_LSB +: TURN_W];
        tim = wr ? wr_tim : rd_tim;
    end

endmodule

// File: rtl/amem_phase_ctrl.sv
module amem_phase_ctrl
    import amem_pkg::*;
(
    input  logic    clk,
    input  logic    rst_n,
    input  logic    start,
    input  timing_t tim_in,
    output phase_e  phase,
    output logic    last,
    output logic    done
);

    typedef struct packed {
        phase_e           phase;
        logic [CNT_W-1:0] cnt;
        timing_t          tim;
        logic             done;
    } ctrl_state_t;

    ctrl_state_t st_d;
    ctrl_state_t st_q;
    logic        last_c;

    always_comb begin
        st_d      = st_q;
        st_d.done = 1'b0;
        last_c    = (st_q.cnt == '0);
        case (st_q.phase)
            PH_IDLE: begin
                if (start) begin
                    st_d.phase = PH_SETUP;
                    st_d.tim   = tim_in;
                    st_d.cnt   = CNT_W'(tim_in.setup);
                end
            end
            PH_SETUP: begin
                if (last_c) begin
                    st_d.phase = PH_STROBE;
                    st_d.cnt   = CNT_W'(st_q.tim.strobe);
                end else begin
                    st_d.cnt = st_q.cnt - 1'b1;
                end
            end
            PH_STROBE: begin
                if (last_c) begin
                    st_d.phase = PH_HOLD;
                    st_d.cnt   = CNT_W'(st_q.tim.hold);
                end else begin
                    st_d.cnt = st_q.cnt - 1'b1;
                end
            end
            PH_HOLD: begin
                if (last_c) begin
                    st_d.phase = PH_TURN;
                    st_d.cnt   = CNT_W'(st_q.tim.turn);
                end else begin
                    st_d.cnt = st_q.cnt - 1'b1;
                end
            end
            PH_TURN: begin
                if (last_c) begin
                    st_d.phase = PH_IDLE;
                    st_d.cnt   = '0;
                    st_d.done  = 1'b1;
                end else begin
                    st_d.cnt = st_q.cnt - 1'b1;
                end
            end
            default: begin
                st_d.phase = PH_IDLE;
                st_d.cnt   = '0;
            end
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q       <= '0;
            st_q.phase <= PH_IDLE;
        end else begin
            st_q <= st_d;
        end
    end

    assign phase = st_q.phase;
    assign last  = last_c;
    assign done  = st_q.done;

endmodule

// File: rtl/amem_bus_drive.sv
module amem_bus_drive
    import amem_pkg::*;
#(
    parameter int DATA_W = 8,
    parameter int ADDR_W = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start,
    input  logic              req_write,
    input  logic [ADDR_W-1:0] req_addr,
    input  logic [DATA_W-1:0] req_wdata,
    input  phase_e            phase,
    input  logic              last,
    input  logic [DATA_W-1:0] mem_din,
    output logic [DATA_W-1:0] rdata,
    output logic              mem_cs_n,
    output logic              mem_oe_n,
    output logic              mem_we_n,
    output logic [ADDR_W-1:0] mem_addr,
    output logic [DATA_W-1:0] mem_dout,
    output logic              mem_dout_en
);

    typedef struct packed {
        logic [ADDR_W-1:0] addr;
        logic [DATA_W-1:0] wdata;
        logic              wr;
        logic [DATA_W-1:0] rdata;
    } bus_state_t;

    bus_state_t bs_d;
    bus_state_t bs_q;
    logic       in_cycle;
    logic       in_strobe;

    always_comb begin
        in_cycle  = (phase == PH_SETUP) || (phase == PH_STROBE) || (phase == PH_HOLD);
        in_strobe = (phase == PH_STROBE);
        bs_d      = bs_q;
        if (start) begin
            bs_d.addr  = req_addr;
            bs_d.wdata = req_wdata;
            bs_d.wr    = req_write;
        end
        if (in_strobe && last && !bs_q.wr) begin
            bs_d.rdata = mem_din;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            bs_q <= '0;
        end else begin
            bs_q <= bs_d;
        end
    end

    assign rdata       = bs_q.rdata;
    assign mem_cs_n    = !in_cycle;
    assign mem_oe_n    = !(in_strobe && !bs_q.wr);
    assign mem_we_n    = !(in_strobe && bs_q.wr);
    assign mem_addr    = bs_q.addr;
    assign mem_dout    = bs_q.wdata;
    assign mem_dout_en = in_cycle && bs_q.wr;

endmodule

// File: rtl/amem_strobe_seq.sv
module amem_strobe_seq
    import amem_pkg::*;
#(
    parameter int DATA_W = 8,
    parameter int ADDR_W = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [31:0]       cfg_word,
    input  logic              req_valid,
    input  logic              req_write,
    input  logic [ADDR_W-1:0] req_addr,
    input  logic [DATA_W-1:0] req_wdata,
    output logic              req_ready,
    output logic              done,
    output logic [DATA_W-1:0] rdata,
    output logic              mem_cs_n,
    output logic              mem_oe_n,
    output logic              mem_we_n,
    output logic [ADDR_W-1:0] mem_addr,
    output logic [DATA_W-1:0] mem_dout,
    output logic              mem_dout_en,
    input  logic [DATA_W-1:0] mem_din
);

    timing_t tim;
    phase_e  phase;
    logic    last;
    logic    start;

    assign req_ready = (phase == PH_IDLE);
    assign start     = req_valid && req_ready;

    amem_cfg_decode u_dec (
        .cfg (cfg_word),
        .wr  (req_write),
        .tim (tim)
    );

    amem_phase_ctrl u_ctrl (
        .clk    (clk),
        .rst_n  (rst_n),
        .start  (start),
        .tim_in (tim),
        .phase  (phase),
        .last   (last),
        .done   (done)
    );

    amem_bus_drive #(
        .DATA_W (DATA_W),
        .ADDR_W (ADDR_W)
    ) u_bus (
        .clk         (clk),
        .rst_n       (rst_n),
        .start       (start),
        .req_write   (req_write),
        .req_addr    (req_addr),
        .req_wdata   (req_wdata),
        .phase       (phase),
        .last        (last),
        .mem_din     (mem_din),
        .rdata       (rdata),
        .mem_cs_n    (mem_cs_n),
        .mem_oe_n    (mem_oe_n),
        .mem_we_n    (mem_we_n),
        .mem_addr    (mem_addr),
        .mem_dout    (mem_dout),
        .mem_dout_en (mem_dout_en)
    );

endmodule

// File: rtl/amem_seq_checker.sv
module amem_seq_checker #(
    parameter int DATA_W = 8,
    parameter int ADDR_W = 2
) (
    input logic              clk,
    input logic              rst_n,
    input logic              req_ready,
    input logic              done,
    input logic              mem_cs_n,
    input logic              mem_oe_n,
    input logic              mem_we_n,
    input logic [ADDR_W-1:0] mem_addr,
    input logic [DATA_W-1:0] mem_dout,
    input logic              mem_dout_en
);

    AST_NO_DUAL_STROBE: assert property (@(posedge clk) disable iff (!rst_n)
        !(!mem_oe_n && !mem_we_n)); // R5

    AST_NO_DRIVE_ON_READ: assert property (@(posedge clk) disable iff (!rst_n)
        !mem_oe_n |-> !mem_dout_en); // R5

    AST_STROBE_IN_SELECT: assert property (@(posedge clk) disable iff (!rst_n)
        (!mem_oe_n || !mem_we_n) |-> !mem_cs_n); // R6

    AST_DONE_ONE_CLOCK: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done); // R4

    AST_DONE_WITH_READY: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> (req_ready && mem_cs_n)); // R4

    AST_BUSY_NOT_READY: assert property (@(posedge clk) disable iff (!rst_n)
        !mem_cs_n |-> !req_ready); // R9

    AST_ADDR_STABLE: assert property (@(posedge clk) disable iff (!rst_n)
        (!mem_cs_n && !$past(mem_cs_n)) |-> $stable(mem_addr)); // R8

    AST_WDATA_STABLE: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_dout_en && $past(mem_dout_en)) |-> $stable(mem_dout)); // R8

endmodule

bind amem_strobe_seq amem_seq_checker #(
    .DATA_W (DATA_W),
    .ADDR_W (ADDR_W)
) u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .req_ready   (req_ready),
    .done        (done),
    .mem_cs_n    (mem_cs_n),
    .mem_oe_n    (mem_oe_n),
    .mem_we_n    (mem_we_n),
    .mem_addr    (mem_addr),
    .mem_dout    (mem_dout),
    .mem_dout_en (mem_dout_en)
);

// File: tb/test_amem_strobe_seq.sv
module test_amem_strobe_seq;

    localparam int DW = 8;
    localparam int AW = 2;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic [31:0]   cfg_word = '0;
    logic          req_valid = 1'b0;
    logic          req_write = 1'b0;
    logic [AW-1:0] req_addr = '0;
    logic [DW-1:0] req_wdata = '0;
    logic          req_ready;
    logic          done;
    logic [DW-1:0] rdata;
    logic          mem_cs_n;
    logic          mem_oe_n;
    logic          mem_we_n;
    logic [AW-1:0] mem_addr;
    logic [DW-1:0] mem_dout;
    logic          mem_dout_en;
    logic [DW-1:0] mem_din;

    logic [DW-1:0] rd_base = 8'h40;
    logic [DW-1:0] oe_cnt = '0;
    logic [DW-1:0] last_rd = '0;

    int n_vec  = 0;
    int n_miss = 0;

    always #2 clk = ~clk;

    // Device model: returned byte advances on every read strobe clock
    always @(posedge clk) oe_cnt <= mem_oe_n ? 8'd0 : oe_cnt + 8'd1;
    assign mem_din = rd_base + oe_cnt;

    amem_strobe_seq #(.DATA_W(DW), .ADDR_W(AW)) i_amem_strobe_seq (
        .clk(clk), .rst_n(rst_n), .cfg_word(cfg_word),
        .req_valid(req_valid), .req_write(req_write), .req_addr(req_addr),
        .req_wdata(req_wdata), .req_ready(req_ready), .done(done),
        .rdata(rdata), .mem_cs_n(mem_cs_n), .mem_oe_n(mem_oe_n),
        .mem_we_n(mem_we_n), .mem_addr(mem_addr), .mem_dout(mem_dout),
        .mem_dout_en(mem_dout_en), .mem_din(mem_din)
    );

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        n_vec++;
        if (!ok) begin
            n_miss++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    function automatic int f_setup(input logic [31:0] c, input logic wr);
        return wr ? int'(c[29:26]) + 1 : int'(c[16:13]) + 1;
    endfunction
    function automatic int f_strobe(input logic [31:0] c, input logic wr);
        return wr ? int'(c[25:20]) + 1 : int'(c[12:7]) + 1;
    endfunction
    function automatic int f_hold(input logic [31:0] c, input logic wr);
        return wr ? int'(c[19:17]) + 1 : int'(c[6:4]) + 1;
    endfunction
    function automatic int f_turn(input logic [31:0] c);
        return int'(c[3:2]) + 1;
    endfunction

    task automatic run_access(input logic wr, input logic [AW-1:0] a,
                              input logic [DW-1:0] wd, input logic [31:0] cfg,
                              input bit disturb);
        int s = 0, sb = 0, h = 0, t = 0, cyc = 0;
        bit bad_strobe = 0, bad_bus = 0, bad_ready = 0, gap = 0;
        logic [DW-1:0] exp_rd;
        @(negedge clk);
        cfg_word = cfg; req_valid = 1'b1; req_write = wr;
        req_addr = a; req_wdata = wd;
        if (!wr) rd_base = 8'($urandom);
        chk(req_ready === 1'b1, "R9", req_ready, 1);
        @(negedge clk);
        req_valid = 1'b0;
        cfg_word = $urandom;                   // R10: late change must be ignored
        req_addr = ~a; req_wdata = ~wd; req_write = ~wr;
        while (!done && cyc < 400) begin
            if (disturb && cyc == 1) req_valid = 1'b1;   // R9: stray request
            if (disturb && cyc == 2) req_valid = 1'b0;
            if (req_ready) bad_ready = 1;
            if ((wr && !mem_oe_n) || (!wr && !mem_we_n)) bad_strobe = 1;
            if (mem_cs_n) begin
                t++;
            end else begin
                if (t != 0) gap = 1;
                if (mem_addr !== a) bad_bus = 1;
                if (wr && (mem_dout !== wd || mem_dout_en !== 1'b1)) bad_bus = 1;
                if (!wr && mem_dout_en !== 1'b0) bad_bus = 1;
                if ((wr && !mem_we_n) || (!wr && !mem_oe_n)) begin
                    if (h != 0) gap = 1;
                    sb++;
                end else if (sb == 0) s++;
                else h++;
            end
            cyc++;
            @(negedge clk);
        end
        req_valid = 1'b0;
        if (wr) begin
            chk(s == f_setup(cfg, 1), "R2 setup", s, f_setup(cfg, 1));
            chk(sb == f_strobe(cfg, 1), "R2 strobe", sb, f_strobe(cfg, 1));
            chk(h == f_hold(cfg, 1), "R2 hold", h, f_hold(cfg, 1));
        end else begin
            chk(s == f_setup(cfg, 0), "R3 setup", s, f_setup(cfg, 0));
            chk(sb == f_strobe(cfg, 0), "R3 strobe", sb, f_strobe(cfg, 0));
            chk(h == f_hold(cfg, 0), "R3 hold", h, f_hold(cfg, 0));
        end
        chk(t == f_turn(cfg), "R4 turnaround", t, f_turn(cfg));
        chk(done === 1'b1 && req_ready === 1'b1, "R4 done with ready", done, 1);
        chk(!bad_strobe, "R5 strobe direction", bad_strobe, 0);
        chk(!gap, "R6 select window", gap, 0);
        chk(!bad_bus, "R8 bus stable", bad_bus, 0);
        chk(!bad_ready, "R9 ready while busy", bad_ready, 0);
        if (!wr) begin
            exp_rd = rd_base + 8'(f_strobe(cfg, 0) - 1);
            last_rd = exp_rd;
        end
        chk(rdata === last_rd, "R7 read capture", rdata, last_rd);
        @(negedge clk);
        chk(done === 1'b0, "R4 done pulse width", done, 0);
        chk(mem_cs_n === 1'b1, "R9 stray request ignored", mem_cs_n, 1);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        chk(1'b0, "watchdog", 0, 1);
        $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_miss);
        $finish;
    end

    initial begin
        void'($urandom(32'd20240611));
        repeat (3) @(negedge clk);
        chk(mem_cs_n === 1'b1 && mem_oe_n === 1'b1 && mem_we_n === 1'b1,
            "R1 strobes in reset", {mem_cs_n, mem_oe_n, mem_we_n}, 7);
        chk(mem_dout_en === 1'b0 && done === 1'b0, "R1 driver/done in reset",
            {mem_dout_en, done}, 0);
        rst_n = 1'b1;
        repeat (2) @(negedge clk);
        chk(req_ready === 1'b1 && mem_cs_n === 1'b1, "R1 idle after reset",
            {req_ready, mem_cs_n}, 3);

        // Directed corners: minimum, maximum, ignored bits, typical word
        run_access(1'b1, 2'd1, 8'hA5, 32'h0000_0000, 1'b0);
        run_access(1'b0, 2'd2, 8'h00, 32'h0000_0000, 1'b0);
        run_access(1'b1, 2'd3, 8'h3C, 32'h3FFF_FFFC, 1'b1);
        run_access(1'b0, 2'd0, 8'h00, 32'h3FFF_FFFC, 1'b1);
        run_access(1'b0, 2'd1, 8'h00, 32'hC000_0003, 1'b0);   // R10
        run_access(1'b1, 2'd2, 8'h5A, 32'h0824_4128, 1'b0);
        run_access(1'b0, 2'd3, 8'h00, 32'h0824_4128, 1'b1);

        for (int k = 0; k < 250; k++) begin
            run_access(1'($urandom), 2'($urandom), 8'($urandom),
                       $urandom, 1'($urandom));
        end

        $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_miss);
        $finish;
    end

endmodule